// File: doc/BRIEF.md
# Bus Control Sequencer for an 8-bit Accumulator Machine

This block is the control unit of a small accumulator computer whose registers, RAM and ALU share one data bus. Each rising edge on a step-request input moves the sequencer forward by one step. Every program instruction starts with two fetch steps. Up to three execute steps follow, and which ones run depends on the 4-bit opcode taken from the instruction input. In each step the block asserts the bus-control lines for that step. It then emits exactly one pulse on the system clock output and releases the lines only after a hold interval, so the datapath latches on a bus that has settled.

The sequencer also stores the ALU carry so that a conditional jump can use it. It stops for good when it decodes a halt instruction. After its own reset it holds a pair of system reset outputs, one of each polarity, for a fixed number of cycles before it accepts any step request.

Top module: `ctl_seq`

## Requirements
- R1: After `rst_n` is released, `sys_rst_o` stays 1 and `sys_rst_n_o` stays 0 for exactly POR_CYC clock cycles, and then they become 0 and 1. Step requests made during that interval produce no pulse and do not advance the sequence.
- R2: These lines are active-low and idle at 1: `mar_in_n`, `ram_out_n`, `ir_in_n`, `ir_out_n`, `a_in_n`, `a_out_n`, `sum_out_n`, `b_in_n`, `pc_out_n`, `pc_load_n`. These lines are active-high and idle at 0: `ram_in`, `out_in`, `pc_en`, `sub_o`, `sys_clk_o`. In reset and between steps, every line is at its idle level.
- R3: A step that pulses asserts its control lines at least one cycle before `sys_clk_o` rises. It keeps `sys_clk_o` high for PULSE_CYC cycles, gives exactly one pulse, and keeps the same lines asserted for at least one cycle after the pulse falls.
- R4: One rising edge of the asynchronous `step_req_i` starts exactly one step. A rising edge that arrives while a step is in progress is ignored.
- R5: Fetch step 1 asserts `pc_out_n` and `mar_in_n`. Fetch step 2 asserts `ram_out_n`, `ir_in_n` and `pc_en`. The opcode is `instr_i[3:0]` as sampled during fetch step 2, and the upper bits are ignored.
- R6: LDA (opcode 1) and STA (opcode 4) first assert `ir_out_n` with `mar_in_n`. LDA then asserts `ram_out_n` with `a_in_n`, and STA then asserts `a_out_n` with `ram_in`. Both then return to fetch step 1.
- R7: ADD (2) and SUB (3) assert `ir_out_n` with `mar_in_n`, then `ram_out_n` with `b_in_n`, then `sum_out_n` with `a_in_n`. For SUB, `sub_o` rises in the second step, stays 1 between the steps, and falls when the third step ends.
- R8: `carry_o` takes the value of `alu_carry_i` only during the sum-out step of ADD or SUB. It keeps that value otherwise and is 0 after reset.
- R9: LDI (5) asserts `ir_out_n` with `a_in_n`, and JMP (6) asserts `ir_out_n` with `pc_load_n`. Each takes one execute step and then returns to fetch.
- R10: JC (7) behaves as JMP when `carry_o` is 1. When `carry_o` is 0, its execute step gives no pulse and the next request performs fetch step 1.
- R11: OUT (0xE) asserts `a_out_n` with `out_in` for one execute step and then returns to fetch.
- R12: HALT (0xF) stops the sequencer. No later request produces a pulse until `rst_n` is asserted.
- R13: Any other opcode gives no pulse in its execute step, and the next request performs fetch step 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_req_i | input | 1 | Asynchronous step request; a rising edge starts one step |
| instr_i | input | INSTR_W | Instruction bus; the low 4 bits are the opcode |
| alu_carry_i | input | 1 | Carry from the ALU |
| mar_in_n | output | 1 | Memory address register load, active-low |
| ram_in | output | 1 | RAM write, active-high |
| ram_out_n | output | 1 | RAM drives the bus, active-low |
| ir_in_n | output | 1 | Instruction register load, active-low |
| ir_out_n | output | 1 | Instruction operand drives the bus, active-low |
| a_in_n | output | 1 | A register load, active-low |
| a_out_n | output | 1 | A register drives the bus, active-low |
| sum_out_n | output | 1 | ALU result drives the bus, active-low |
| b_in_n | output | 1 | B register load, active-low |
| sub_o | output | 1 | ALU subtract select, active-high |
| out_in | output | 1 | Output register load, active-high |
| pc_en | output | 1 | Program counter increment, active-high |
| pc_out_n | output | 1 | Program counter drives the bus, active-low |
| pc_load_n | output | 1 | Program counter load, active-low |
| sys_clk_o | output | 1 | Datapath clock pulse, active-high |
| carry_o | output | 1 | Stored carry flag |
| sys_rst_o | output | 1 | Datapath reset, active-high |
| sys_rst_n_o | output | 1 | Datapath reset, active-low |

## Verification
Every opcode class is run through the whole fetch and execute sequence. The control word sampled at each pulse is compared with the expected set of lines, so a wrong pairing or a wrong polarity of any line shows up. JC is run once with the stored carry at 1, after an ADD that produces a carry, and once with it at 0, after a SUB without carry. The ALU carry is held at 1 through the earlier ADD steps, which shows that the flag changes only in the sum-out step. The tests also cover extra requests sent in the middle of a step or during power-up, the upper bits of the instruction set to non-zero values, an unknown opcode and HALT. Together these separate "ignored", "no pulse but advance" and "stopped" behaviour, each seen through the lines that the following step drives.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_LDA  = 4'h1;
    localparam logic [OP_W-1:0] OP_ADD  = 4'h2;
    localparam logic [OP_W-1:0] OP_SUB  = 4'h3;
    localparam logic [OP_W-1:0] OP_STA  = 4'h4;
    localparam logic [OP_W-1:0] OP_LDI  = 4'h5;
    localparam logic [OP_W-1:0] OP_JMP  = 4'h6;
    localparam logic [OP_W-1:0] OP_JC   = 4'h7;
    localparam logic [OP_W-1:0] OP_OUT  = 4'hE;
    localparam logic [OP_W-1:0] OP_HALT = 4'hF;

    typedef enum logic [2:0] {PH_F1, PH_F2, PH_E1, PH_E2, PH_E3} phase_e;
    typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_STOP} seq_st_e;

    // Control word, every field active-high inside the block
    typedef struct packed {
        logic mar_in;
        logic ram_in;
        logic ram_out;
        logic ir_in;
        logic ir_out;
        logic a_in;
        logic a_out;
        logic sum_out;
        logic b_in;
        logic out_in;
        logic pc_en;
        logic pc_out;
        logic pc_load;
    } ctl_t;

    typedef struct packed {
        ctl_t   ctl;
        logic   fire;       // step issues a clock pulse
        logic   sub_set;    // raise subtract select
        logic   sample_cy;  // capture ALU carry at pulse
        logic   halt;       // enter stopped state
        phase_e nxt;        // phase after this step
    } dec_t;

endpackage

// File: rtl/req_edge.sv
module req_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else if (g == 0) sync_q[g] <= req_i;
                else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R4

endmodule

// File: rtl/por_timer.sv
module por_timer #(
    parameter int POR_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam int PW = $clog2(POR_CYC + 1);
    localparam logic [PW-1:0] LIMIT = PW'(POR_CYC);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LIMIT);

    AST_POR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o); // R1

endmodule

// File: rtl/step_decode.sv
module step_decode
    import ctl_seq_pkg::*;
(
    input  phase_e          ph_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            cy_i,
    output dec_t            dec_o
);
    always_comb begin
        dec_o     = '0;
        dec_o.nxt = PH_F1;
        case (ph_i)
            PH_F1: begin
                dec_o.ctl.pc_out = 1'b1;
                dec_o.ctl.mar_in = 1'b1;
                dec_o.fire       = 1'b1;
                dec_o.nxt        = PH_F2;
            end
            PH_F2: begin
                dec_o.ctl.ram_out = 1'b1;
                dec_o.ctl.ir_in   = 1'b1;
                dec_o.ctl.pc_en   = 1'b1;
                dec_o.fire        = 1'b1;
                dec_o.nxt         = PH_E1;
            end
            PH_E1: begin
                case (op_i)
                    OP_LDA, OP_ADD, OP_SUB, OP_STA: begin
                        dec_o.ctl.ir_out = 1'b1;
                        dec_o.ctl.mar_in = 1'b1;
                        dec_o.fire       = 1'b1;
                        dec_o.nxt        = PH_E2;
                    end
                    OP_LDI: begin
                        dec_o.ctl.ir_out = 1'b1;
                        dec_o.ctl.a_in   = 1'b1;
                        dec_o.fire       = 1'b1;
                    end
                    OP_JMP: begin
                        dec_o.ctl.ir_out  = 1'b1;
                        dec_o.ctl.pc_load = 1'b1;
                        dec_o.fire        = 1'b1;
                    end
                    OP_JC: begin
                        dec_o.ctl.ir_out  = cy_i;
                        dec_o.ctl.pc_load = cy_i;
                        dec_o.fire        = cy_i;
                    end
                    OP_OUT: begin
                        dec_o.ctl.a_out  = 1'b1;
                        dec_o.ctl.out_in = 1'b1;
                        dec_o.fire       = 1'b1;
                    end
                    OP_HALT: dec_o.halt = 1'b1;
                    default: ;
                endcase
            end
            PH_E2: begin
                case (op_i)
                    OP_LDA: begin
                        dec_o.ctl.ram_out = 1'b1;
                        dec_o.ctl.a_in    = 1'b1;
                        dec_o.fire        = 1'b1;
                    end
                    OP_STA: begin
                        dec_o.ctl.a_out  = 1'b1;
                        dec_o.ctl.ram_in = 1'b1;
                        dec_o.fire       = 1'b1;
                    end
                    OP_ADD, OP_SUB: begin
                        dec_o.ctl.ram_out = 1'b1;
                        dec_o.ctl.b_in    = 1'b1;
                        dec_o.fire        = 1'b1;
                        dec_o.sub_set     = (op_i == OP_SUB);
                        dec_o.nxt         = PH_E3;
                    end
                    default: ;
                endcase
            end
            PH_E3: begin
                if (op_i == OP_ADD || op_i == OP_SUB) begin
                    dec_o.ctl.sum_out = 1'b1;
                    dec_o.ctl.a_in    = 1'b1;
                    dec_o.fire        = 1'b1;
                    dec_o.sample_cy   = 1'b1;
                end
            end
            default: dec_o.halt = 1'b1;
        endcase
    end

endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
    import ctl_seq_pkg::*;
#(
    parameter int INSTR_W   = 8,
    parameter int SYNC_STG  = 2,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 2,
    parameter int POR_CYC   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_req_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               alu_carry_i,
    output logic               mar_in_n,
    output logic               ram_in,
    output logic               ram_out_n,
    output logic               ir_in_n,
    output logic               ir_out_n,
    output logic               a_in_n,
    output logic               a_out_n,
    output logic               sum_out_n,
    output logic               b_in_n,
    output logic               sub_o,
    output logic               out_in,
    output logic               pc_en,
    output logic               pc_out_n,
    output logic               pc_load_n,
    output logic               sys_clk_o,
    output logic               carry_o,
    output logic               sys_rst_o,
    output logic               sys_rst_n_o
);
    localparam int MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
    localparam int CW     = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] SETUP_END = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HOLD_END  = CW'(HOLD_CYC - 1);

    typedef struct packed {
        seq_st_e         st;
        phase_e          ph;
        logic [OP_W-1:0] op;
        logic            cy;
        logic            sub;
        ctl_t            ctl;
        logic            pclk;
        logic [CW-1:0]   cnt;
    } core_t;

    core_t core_d, core_q;
    logic  rise;
    logic  por_done;
    dec_t  dec;

    req_edge #(.STAGES(SYNC_STG)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (step_req_i),
        .rise_o(rise)
    );

    por_timer #(.POR_CYC(POR_CYC)) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .done_o(por_done)
    );

    step_decode u_dec (
        .ph_i (core_q.ph),
        .op_i (core_q.op),
        .cy_i (core_q.cy),
        .dec_o(dec)
    );

    always_comb begin
        core_d = core_q;
        case (core_q.st)
            ST_IDLE: begin
                if (rise && por_done) begin
                    if (dec.halt) begin
                        core_d.st = ST_STOP;
                    end else if (dec.fire) begin
                        core_d.st  = ST_SETUP;
                        core_d.ctl = dec.ctl;
                        core_d.cnt = '0;
                        if (dec.sub_set) core_d.sub = 1'b1;
                    end else begin
                        core_d.ph = dec.nxt;
                    end
                end
            end
            ST_SETUP: begin
                if (core_q.cnt == SETUP_END) begin
                    core_d.st   = ST_PULSE;
                    core_d.pclk = 1'b1;
                    core_d.cnt  = '0;
                    if (dec.sample_cy) core_d.cy = alu_carry_i;
                end else begin
                    core_d.cnt = core_q.cnt + 1'b1;
                end
            end
            ST_PULSE: begin
                if (core_q.cnt == PULSE_END) begin
                    core_d.st   = ST_HOLD;
                    core_d.pclk = 1'b0;
                    core_d.cnt  = '0;
                    if (core_q.ph == PH_F2) core_d.op = instr_i[OP_W-1:0];
                end else begin
                    core_d.cnt = core_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (core_q.cnt == HOLD_END) begin
                    core_d.st  = ST_IDLE;
                    core_d.ctl = '0;
                    core_d.ph  = dec.nxt;
                    if (core_q.ph == PH_E3) core_d.sub = 1'b0;
                end else begin
                    core_d.cnt = core_q.cnt + 1'b1;
                end
            end
            ST_STOP: ;
            default: core_d.st = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign mar_in_n    = ~core_q.ctl.mar_in;
    assign ram_in      =  core_q.ctl.ram_in;
    assign ram_out_n   = ~core_q.ctl.ram_out;
    assign ir_in_n     = ~core_q.ctl.ir_in;
    assign ir_out_n    = ~core_q.ctl.ir_out;
    assign a_in_n      = ~core_q.ctl.a_in;
    assign a_out_n     = ~core_q.ctl.a_out;
    assign sum_out_n   = ~core_q.ctl.sum_out;
    assign b_in_n      = ~core_q.ctl.b_in;
    assign sub_o       =  core_q.sub;
    assign out_in      =  core_q.ctl.out_in;
    assign pc_en       =  core_q.ctl.pc_en;
    assign pc_out_n    = ~core_q.ctl.pc_out;
    assign pc_load_n   = ~core_q.ctl.pc_load;
    assign sys_clk_o   =  core_q.pclk;
    assign carry_o     =  core_q.cy;
    assign sys_rst_o   = ~por_done;
    assign sys_rst_n_o =  por_done;

    AST_NO_PULSE_IN_POR: assert property (@(posedge clk) disable iff (!rst_n)
        !por_done |-> !core_q.pclk); // R1
    AST_PULSE_HAS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.pclk |-> (core_q.ctl != '0)); // R3
    AST_CTRL_STABLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.pclk |-> $stable(core_q.ctl)); // R3
    AST_SUB_ONLY_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.sub |-> (core_q.op == OP_SUB)); // R7
    AST_CARRY_ONLY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_q.cy) |-> ($past(core_q.ph) == PH_E3)); // R8
    AST_STOP_IS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_STOP) |=> (core_q.st == ST_STOP) && !core_q.pclk); // R12

endmodule

// File: tb/ctl_seq_tb_top.sv
module ctl_seq_tb_top;

    localparam int POR = 16;
    localparam int PW  = 3;

    // Pin vector order: mar_in_n ram_in ram_out_n ir_in_n ir_out_n a_in_n a_out_n
    //                   sum_out_n b_in_n sub_o out_in pc_en pc_out_n pc_load_n
    localparam logic [13:0] IDLE    = 14'b10111111100011;
    localparam logic [13:0] M_MAR   = 14'd1 << 13;
    localparam logic [13:0] M_RIN   = 14'd1 << 12;
    localparam logic [13:0] M_ROUT  = 14'd1 << 11;
    localparam logic [13:0] M_IRIN  = 14'd1 << 10;
    localparam logic [13:0] M_IROUT = 14'd1 << 9;
    localparam logic [13:0] M_AIN   = 14'd1 << 8;
    localparam logic [13:0] M_AOUT  = 14'd1 << 7;
    localparam logic [13:0] M_SUM   = 14'd1 << 6;
    localparam logic [13:0] M_BIN   = 14'd1 << 5;
    localparam logic [13:0] M_SUB   = 14'd1 << 4;
    localparam logic [13:0] M_OIN   = 14'd1 << 3;
    localparam logic [13:0] M_PCEN  = 14'd1 << 2;
    localparam logic [13:0] M_PCOUT = 14'd1 << 1;
    localparam logic [13:0] M_PCLD  = 14'd1 << 0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_req = 1'b0;
    logic [7:0] instr = 8'h00;
    logic       alu_cy = 1'b0;
    logic mar_in_n, ram_in, ram_out_n, ir_in_n, ir_out_n, a_in_n, a_out_n;
    logic sum_out_n, b_in_n, sub_o, out_in, pc_en, pc_out_n, pc_load_n;
    logic sys_clk, carry, sys_rst, sys_rst_n;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    ctl_seq #(.INSTR_W(8), .SYNC_STG(2), .SETUP_CYC(2), .PULSE_CYC(PW),
              .HOLD_CYC(2), .POR_CYC(POR)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_req_i(step_req), .instr_i(instr),
        .alu_carry_i(alu_cy), .mar_in_n(mar_in_n), .ram_in(ram_in),
        .ram_out_n(ram_out_n), .ir_in_n(ir_in_n), .ir_out_n(ir_out_n),
        .a_in_n(a_in_n), .a_out_n(a_out_n), .sum_out_n(sum_out_n),
        .b_in_n(b_in_n), .sub_o(sub_o), .out_in(out_in), .pc_en(pc_en),
        .pc_out_n(pc_out_n), .pc_load_n(pc_load_n), .sys_clk_o(sys_clk),
        .carry_o(carry), .sys_rst_o(sys_rst), .sys_rst_n_o(sys_rst_n)
    );

    logic [13:0] pins;
    assign pins = {mar_in_n, ram_in, ram_out_n, ir_in_n, ir_out_n, a_in_n, a_out_n,
                   sum_out_n, b_in_n, sub_o, out_in, pc_en, pc_out_n, pc_load_n};

    // Pulse monitor, sampled on the falling edge
    int          npulse = 0;
    int          width = 0;
    logic [13:0] cap, pre, post, prev_pins = IDLE;
    logic        prev_clk = 1'b0;

    always @(negedge clk) begin
        if (sys_clk && !prev_clk) begin
            npulse <= npulse + 1;
            cap    <= pins;
            pre    <= prev_pins;
            width  <= 1;
        end else if (sys_clk) begin
            width <= width + 1;
        end
        if (!sys_clk && prev_clk) post <= pins;
        prev_pins <= pins;
        prev_clk  <= sys_clk;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One request; optionally a second request inside the running step
    task automatic do_step(input string tag, input logic [13:0] mask, input int pulses,
                           input bit extra, input bit sub_after);
        @(negedge clk);
        npulse = 0;
        step_req = 1'b1;
        repeat (3) @(negedge clk);
        step_req = 1'b0;
        repeat (2) @(negedge clk);
        if (extra) step_req = 1'b1;
        repeat (3) @(negedge clk);
        step_req = 1'b0;
        repeat (20) @(negedge clk);
        chk({tag, " R3 R4 pulse count"}, npulse, pulses);
        if (pulses == 1) begin
            chk({tag, " control word"}, cap, IDLE ^ mask);
            chk({tag, " R3 setup"}, pre, IDLE ^ mask);
            chk({tag, " R3 hold"}, post, IDLE ^ mask);
            chk({tag, " R3 width"}, width, PW);
        end
        chk({tag, " R2 idle after step"}, pins, IDLE ^ (sub_after ? M_SUB : 14'd0));
    endtask

    task automatic fetch(input logic [7:0] word, input string tag);
        do_step({tag, " R5 fetch1"}, M_MAR | M_PCOUT, 1, 0, 0);
        instr = word;
        do_step({tag, " R5 fetch2"}, M_ROUT | M_IRIN | M_PCEN, 1, 0, 0);
        instr = 8'h00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset sys_rst", sys_rst, 1);
        chk("R1 reset sys_rst_n", sys_rst_n, 0);
        chk("R2 reset pins idle", pins, IDLE);
        chk("R8 reset carry clear", carry, 0);
        rst_n = 1'b1;
        for (int i = 1; i < POR; i++) begin
            @(negedge clk);
            if (i == 2) step_req = 1'b1;
            if (i == 6) step_req = 1'b0;
            if (sys_rst !== 1'b1 || sys_rst_n !== 1'b0)
                chk("R1 reset held", {sys_rst, sys_rst_n}, 2'b10);
        end
        @(negedge clk);
        chk("R1 reset released", {sys_rst, sys_rst_n}, 2'b01);
        repeat (10) @(negedge clk);
        chk("R1 request in reset ignored", npulse, 0);
    endtask

    task automatic t_lda();
        fetch(8'hA1, "LDA");
        do_step("R6 LDA e1", M_IROUT | M_MAR, 1, 0, 0);
        do_step("R6 LDA e2", M_ROUT | M_AIN, 1, 0, 0);
    endtask

    task automatic t_sta();
        fetch(8'h34, "STA");
        do_step("R6 STA e1", M_IROUT | M_MAR, 1, 0, 0);
        do_step("R6 STA e2", M_AOUT | M_RIN, 1, 0, 0);
    endtask

    task automatic t_add_carry();
        alu_cy = 1'b1;
        fetch(8'h52, "ADD");
        do_step("R7 ADD e1", M_IROUT | M_MAR, 1, 0, 0);
        do_step("R7 ADD e2", M_ROUT | M_BIN, 1, 0, 0);
        chk("R8 carry unchanged before sum step", carry, 0);
        do_step("R7 ADD e3", M_SUM | M_AIN, 1, 0, 0);
        chk("R8 carry captured", carry, 1);
        alu_cy = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 carry held", carry, 1);
    endtask

    task automatic t_jc_taken();
        fetch(8'h07, "JC1");
        do_step("R10 JC taken", M_IROUT | M_PCLD, 1, 0, 0);
    endtask

    task automatic t_sub();
        alu_cy = 1'b0;
        fetch(8'hF3, "SUB");
        do_step("R7 SUB e1", M_IROUT | M_MAR, 1, 0, 0);
        do_step("R7 SUB e2", M_ROUT | M_BIN | M_SUB, 1, 0, 1);
        chk("R7 sub held between steps", sub_o, 1);
        do_step("R7 SUB e3", M_SUM | M_AIN | M_SUB, 1, 0, 0);
        chk("R7 sub dropped", sub_o, 0);
        chk("R8 carry from sub", carry, 0);
    endtask

    task automatic t_jc_not();
        fetch(8'h07, "JC0");
        do_step("R10 JC not taken", 14'd0, 0, 0, 0);
        do_step("R10 back to fetch1", M_MAR | M_PCOUT, 1, 0, 0);
        instr = 8'h05;
        do_step("R10 fetch2", M_ROUT | M_IRIN | M_PCEN, 1, 0, 0);
        do_step("R9 LDI", M_IROUT | M_AIN, 1, 0, 0);
    endtask

    task automatic t_jmp_out();
        fetch(8'h06, "JMP");
        do_step("R9 R4 JMP with extra request", M_IROUT | M_PCLD, 1, 1, 0);
        fetch(8'h0E, "OUT");
        do_step("R11 OUT", M_AOUT | M_OIN, 1, 0, 0);
    endtask

    task automatic t_unknown();
        fetch(8'h09, "UNK");
        do_step("R13 unknown op", 14'd0, 0, 0, 0);
        do_step("R13 back to fetch1", M_MAR | M_PCOUT, 1, 0, 0);
        instr = 8'h0E;
        do_step("R13 fetch2", M_ROUT | M_IRIN | M_PCEN, 1, 0, 0);
        do_step("R13 OUT after", M_AOUT | M_OIN, 1, 0, 0);
    endtask

    task automatic t_halt();
        alu_cy = 1'b1;
        fetch(8'h02, "ADD2");
        do_step("R7 ADD2 e1", M_IROUT | M_MAR, 1, 0, 0);
        do_step("R7 ADD2 e2", M_ROUT | M_BIN, 1, 0, 0);
        do_step("R7 ADD2 e3", M_SUM | M_AIN, 1, 0, 0);
        alu_cy = 1'b0;
        fetch(8'h0F, "HALT");
        do_step("R12 halt step", 14'd0, 0, 0, 0);
        do_step("R12 halted 1", 14'd0, 0, 0, 0);
        do_step("R12 halted 2", 14'd0, 0, 0, 0);
        do_reset();
        do_step("R12 run after reset", M_MAR | M_PCOUT, 1, 0, 0);
    endtask

    initial begin
        do_reset();
        t_lda();
        t_sta();
        t_add_carry();
        t_jc_taken();
        t_sub();
        t_jc_not();
        t_jmp_out();
        t_unknown();
        t_halt();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule